// File: doc/BRIEF.md
# Latch-Based Single-Write-Port RAM

This block is a small synchronous random-access memory whose storage bits are level-sensitive latches instead of edge-triggered flip-flops. A single row of latches sits on the write data path, one per data bit. That row is transparent while the clock is low, and it acts as the shared master stage for every word. Each stored bit is a single latch that is transparent while the clock is high. It takes its input from the shared row and opens only when its word's gated clock is active. Seen from the ports, the block behaves cycle for cycle like a flip-flop RAM that has the same interface.

There is one write port and one address. Write enable and address are captured while the clock is low. Data present at a rising edge with write enable high is committed to the addressed word and can be read in the next cycle. Reads are combinational from the address. The storage is arranged as rows that each hold one, two or four interleaved words. A row decoder and a column multiplexer, driven by the low address bits, select the word on both the write side and the read side.

Top module: `latch_ram`

## Requirements
- R1: When write enable is high before a rising clock edge, the write data present at that edge is stored in the addressed word and appears on the read data port once that address is presented, from the following cycle onwards.
- R2: When write enable is low at a rising edge, no stored word changes, whatever the address and write data.
- R3: Read data follows the address combinationally: a change of address within one clock phase, with no clock edge in between, shows the newly addressed word.
- R4: A write changes only the addressed word, and at most one word gate is open at any time. Every other word keeps its value.
- R5: Write data that changes during the high phase after a rising edge does not alter the word written at that edge.
- R6: Write enable and address that change during the high phase after a rising edge have no effect on that cycle's write. The values present while the clock was low decide the write.
- R7: While reset is low, and at the first two rising edges after its release, writes are ignored. Stored contents are kept across reset. The third rising edge after release accepts writes.
- R8: The column-mux parameter may be 1, 2 or 4. The word at address A sits in row A divided by the ratio, at column A modulo the ratio. Port behaviour is identical for all three settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Low phase: capture of data and control. High phase: storage update |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| we | input | 1 | Write enable, sampled while the clock is low |
| addr | input | ADDR_W | Word address for both read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data of the addressed word |

## Verification
The hardest situation to reach is one where the inputs move while the clock is high. At that point the shared master row and the captured control are closed, but the word latch is open and copying. The bench reaches this state by changing write data, address and write enable two nanoseconds after a rising edge, in the middle of the high phase, and then checking that only the word chosen during the low phase holds the data from the edge. A second hard case is the two-edge window after reset release, which the bench probes with writes at exactly those edges. All three column-mux ratios run side by side on the same stimulus, with exhaustive sweeps over every word.

// File: rtl/lram_pkg.sv
`timescale 1ns/1ps
package lram_pkg;

  // number of address bits that pick a column inside one physical row
  function automatic int csel_bits(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 0;
  endfunction

endpackage

// File: rtl/lram_master_row.sv
`timescale 1ns/1ps
// Shared master row: one latch per data bit, open while clk is low.
module lram_master_row #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hold_q
);

  logic [DATA_W-1:0] din_buf;

  // input buffer placed ahead of the latch row
  assign din_buf = din;

  always_latch begin
    if (!clk) hold_q <= din_buf;
  end

endmodule

// File: rtl/lram_wr_ctrl.sv
`timescale 1ns/1ps
// Captures enable and address in the low phase and forms one gated
// clock per word from a row decode and a column decode.
module lram_wr_ctrl #(
  parameter int ADDR_W  = 4,
  parameter int COL_MUX = 4
) (
  input  logic                  clk,
  input  logic                  rst_s,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  output logic [(1<<ADDR_W)-1:0] wgate
);

  localparam int WORDS  = 1 << ADDR_W;
  localparam int ROWS   = WORDS / COL_MUX;
  localparam int CSEL_W = lram_pkg::csel_bits(COL_MUX);

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ROWS-1:0]   row_hot;
  logic [COL_MUX-1:0] col_hot;
  logic              open_phase;

  always_latch begin
    if (!rst_s)   we_q <= 1'b0;
    else if (!clk) we_q <= we;
  end

  always_latch begin
    if (!clk) addr_q <= addr;
  end

  always_comb begin
    row_hot = '0;
    row_hot[addr_q[ADDR_W-1:CSEL_W]] = 1'b1;
  end

  if (COL_MUX == 1) begin : g_single_col
    assign col_hot = 1'b1;
  end else begin : g_col_dec
    always_comb begin
      col_hot = '0;
      col_hot[addr_q[CSEL_W-1:0]] = 1'b1;
    end
  end

  assign open_phase = clk & we_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COL_MUX; c++) begin : g_col
      assign wgate[r*COL_MUX + c] = open_phase & row_hot[r] & col_hot[c];
    end
  end

endmodule

// File: rtl/lram_cell_array.sv
`timescale 1ns/1ps
// Storage: one latch word per gated clock, open while its gate is high.
// Bits of the words sharing a row are interleaved, column-minor.
module lram_cell_array #(
  parameter int DATA_W  = 8,
  parameter int ROWS    = 4,
  parameter int COL_MUX = 4
) (
  input  logic [ROWS*COL_MUX-1:0]                  wgate,
  input  logic [DATA_W-1:0]                        master_q,
  output logic [ROWS-1:0][COL_MUX*DATA_W-1:0]      cells
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COL_MUX; c++) begin : g_word
      logic [DATA_W-1:0] word_q;

      always_latch begin
        if (wgate[r*COL_MUX + c]) word_q <= master_q;
      end

      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign cells[r][b*COL_MUX + c] = word_q[b];
      end
    end
  end

endmodule

// File: rtl/lram_read_path.sv
`timescale 1ns/1ps
// Asynchronous read: row select first, then a ratio-to-1 column mux.
module lram_read_path #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int COL_MUX = 4
) (
  input  logic [(1<<ADDR_W)/COL_MUX-1:0][COL_MUX*DATA_W-1:0] cells,
  input  logic [ADDR_W-1:0]                                  addr,
  output logic [DATA_W-1:0]                                  rdata
);

  localparam int CSEL_W = lram_pkg::csel_bits(COL_MUX);

  logic [COL_MUX*DATA_W-1:0] row_bits;

  assign row_bits = cells[addr[ADDR_W-1:CSEL_W]];

  if (COL_MUX == 1) begin : g_direct
    assign rdata = row_bits;
  end else begin : g_mux
    logic [CSEL_W-1:0] col;
    assign col = addr[CSEL_W-1:0];
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic [COL_MUX-1:0] group;
      assign group    = row_bits[b*COL_MUX +: COL_MUX];
      assign rdata[b] = group[col];
    end
  end

endmodule

// File: rtl/latch_ram.sv
`timescale 1ns/1ps
module latch_ram #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int COL_MUX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int ROWS  = WORDS / COL_MUX;

  logic                                 rst_meta;
  logic                                 rst_sync_n;
  logic [DATA_W-1:0]                    master_q;
  logic [WORDS-1:0]                     wgate;
  logic [ROWS-1:0][COL_MUX*DATA_W-1:0]  cells;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  lram_master_row #(.DATA_W(DATA_W)) u_master (
    .clk    (clk),
    .din    (wdata),
    .hold_q (master_q)
  );

  lram_wr_ctrl #(.ADDR_W(ADDR_W), .COL_MUX(COL_MUX)) u_ctrl (
    .clk   (clk),
    .rst_s (rst_sync_n),
    .we    (we),
    .addr  (addr),
    .wgate (wgate)
  );

  lram_cell_array #(.DATA_W(DATA_W), .ROWS(ROWS), .COL_MUX(COL_MUX)) u_cells (
    .wgate    (wgate),
    .master_q (master_q),
    .cells    (cells)
  );

  lram_read_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COL_MUX(COL_MUX)) u_read (
    .cells (cells),
    .addr  (addr),
    .rdata (rdata)
  );

endmodule

// File: rtl/lram_checker.sv
`timescale 1ns/1ps
module lram_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                               clk,
  input logic                               rst_s,
  input logic                               we,
  input logic [ADDR_W-1:0]                  addr,
  input logic [DATA_W-1:0]                  wdata,
  input logic [DATA_W-1:0]                  rdata,
  input logic [(1<<ADDR_W)*DATA_W-1:0]      store,
  input logic [(1<<ADDR_W)-1:0]             wgate
);

  // R1
  write_commit_chk: assert property (@(posedge clk) disable iff (!rst_s)
    we |=> (addr != $past(addr) || rdata == $past(wdata)));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !we |=> $stable(store));

  // R3
  read_steady_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !we |=> (addr != $past(addr) || rdata == $past(rdata)));

  // R4
  single_gate_chk: assert property (@(negedge clk) disable iff (!rst_s)
    $onehot0(wgate));

endmodule

bind latch_ram lram_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_s (rst_sync_n),
  .we    (we),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .store (cells),
  .wgate (wgate)
);

// File: tb/latch_ram_test.sv
`timescale 1ns/1ps
module latch_ram_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rd4, rd2, rd1;
  logic [7:0] model [16];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  latch_ram #(.DATA_W(8), .ADDR_W(4), .COL_MUX(4)) uut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rd4));
  latch_ram #(.DATA_W(8), .ADDR_W(4), .COL_MUX(2)) uut_r2 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rd2));
  latch_ram #(.DATA_W(8), .ADDR_W(4), .COL_MUX(1)) uut_r1 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rd1));

  task automatic check(input string tag, input string inst, input int a,
                       input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%0d actual=%h expected=%h", tag, inst, a, got, exp);
    end
  endtask

  // one cycle: drive in low phase, return 2 ns after the rising edge
  task automatic cycle(input logic rn, input logic w, input logic [3:0] a,
                       input logic [7:0] d);
    @(negedge clk);
    #1;
    rst_n = rn; we = w; addr = a; wdata = d;
    @(posedge clk);
    #2;
  endtask

  // R8: every read compared on all three column-mux ratios
  task automatic check_all(input string tag);
    for (int a = 0; a < 16; a++) begin
      we = 1'b0; addr = a[3:0];
      #1;
      check(tag, "ratio4", a, rd4, model[a]);
      check(tag, "ratio2", a, rd2, model[a]);
      check(tag, "ratio1", a, rd1, model[a]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: fill every word, read back in later cycles
    for (int a = 0; a < 16; a++) begin
      cycle(1'b1, 1'b1, a[3:0], 8'((a * 29 + 7) & 8'hff));
      model[a] = 8'((a * 29 + 7) & 8'hff);
    end
    check_all("R1");

    // R2: write enable low, other data and addresses
    for (int a = 0; a < 16; a++) cycle(1'b1, 1'b0, a[3:0], ~model[a]);
    check_all("R2");

    // R4 R8: single-word writes, full readback after each
    for (int t = 0; t < 16; t++) begin
      cycle(1'b1, 1'b1, t[3:0], 8'((t * 53 + 200) & 8'hff));
      model[t] = 8'((t * 53 + 200) & 8'hff);
      check_all("R4 R8");
    end

    // R3: two addresses within one low phase, no edge between
    @(negedge clk);
    #1; we = 1'b0; addr = 4'd2;
    #1; check("R3", "ratio4", 2, rd4, model[2]);
    addr = 4'd13;
    #1; check("R3", "ratio4", 13, rd4, model[13]);
    check("R3", "ratio1", 13, rd1, model[13]);

    // R5: data moves in the high phase after the edge
    cycle(1'b1, 1'b1, 4'd9, 8'hA5);
    wdata = 8'h3C;
    #1;
    model[9] = 8'hA5;
    check_all("R5");

    // R6: enable and address move in the high phase
    cycle(1'b1, 1'b1, 4'd10, 8'h66);
    we = 1'b1; addr = 4'd11; wdata = 8'h77;
    #2;
    we = 1'b0;
    model[10] = 8'h66;
    check_all("R6");

    // R7: writes in reset and at the two edges after release are lost
    cycle(1'b0, 1'b1, 4'd0, 8'hEE);
    cycle(1'b0, 1'b1, 4'd4, 8'hEE);
    cycle(1'b1, 1'b1, 4'd1, 8'hEE);
    cycle(1'b1, 1'b1, 4'd2, 8'hEE);
    check_all("R7");
    cycle(1'b1, 1'b1, 4'd3, 8'h5A);
    model[3] = 8'h5A;
    check_all("R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule